// File: doc/BRIEF.md
# SPI Command Frame Generator

This block is the master side of the command phase of a register and DMA access protocol that runs over SPI. One strobe presents an 8-bit opcode, a 24-bit address, a 32-bit data word, a 24-bit transfer size, a clockless flag and a CRC enable. The block arranges the header bytes that the opcode calls for. It drives chip select low and shifts the bytes out on MOSI, most significant bit first, in SPI mode 0. When CRC is enabled it adds a CRC7 byte at the end.

The CRC is built one bit at a time, in step with the serial clock, so no lookup table is stored. Reading the response and running the data phase belong to neighbouring logic. This block only reports busy, a one-cycle done pulse, and a one-cycle error pulse when the opcode is not recognised.

Top module: `spi_cmd_framer`

## Requirements
- R1: The accepted opcodes are 0xC1 to 0xCA and 0xCF. Any other opcode pulses `bad_op_o` for one cycle, seen the cycle after the strobe. Chip select, `busy_o` and SCK then stay idle.
- R2: A single-read (0xCA) header is the opcode followed by address bytes [23:16], [15:8] and [7:0]. Terminate (0xC5) and repeat (0xC6) follow the opcode with three 0x00 bytes. Reset (0xCF) follows it with three 0xFF bytes.
- R3: An internal access sends address[15:8] with bit 7 ORed with the clockless flag, then address[7:0]. The read form (0xC4) then sends 0x00. The write form (0xC3) then sends the four data bytes, most significant byte first.
- R4: A DMA read or write (0xC2/0xC1) sends the three address bytes, then size[15:8] and size[7:0]. The extended forms (0xC8/0xC7) send size[23:16], [15:8] and [7:0] instead.
- R5: A single write (0xC9) sends the three address bytes, then the four data bytes, most significant byte first.
- R6: With CRC enabled, one trailing byte follows the header. It equals the 7-bit CRC shifted left by one, with bit 0 at 0. The CRC starts at 0x7F, uses polynomial x^7+x^3+1, and takes in every header byte MSB first.
- R7: With CRC disabled, the trailing byte is omitted, so the frame is exactly one byte shorter.
- R8: SPI mode 0: SCK is low whenever chip select is high. MOSI changes only while SCK is low and is valid at every rising SCK edge. Each SCK half period lasts SCK_HALF clocks.
- R9: `busy_o` goes high and `cs_n_o` goes low at the clock edge that samples the strobe. After nbits*2*SCK_HALF clocks, `cs_n_o` returns high, `busy_o` falls and `done_o` pulses for one cycle, all on the same edge.
- R10: A strobe while busy is ignored. It does not restart or alter the frame in progress, and an invalid opcode given then raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, one cycle |
| opcode_i | input | 8 | Command opcode |
| addr_i | input | 24 | Target address |
| wdata_i | input | 32 | Write data word |
| size_i | input | 24 | Transfer size |
| clockless_i | input | 1 | Set bit 7 of the internal-access address byte |
| crc_en_i | input | 1 | Append the CRC7 byte |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| bad_op_o | output | 1 | One-cycle pulse for an unknown opcode |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Chip select, active low |

## Verification
The strobe is driven after a falling clock edge and held for one cycle. `busy_o`, `cs_n_o` and `bad_op_o` are therefore sampled at the very next falling edge, one register stage later. `done_o` is expected exactly nbits*2*SCK_HALF+1 falling edges after the strobe, where nbits comes from the opcode and the CRC flag, and the bench counts falling edges to test that exact cycle. MOSI is captured at each falling clock edge where SCK is seen to have just risen. The captured bit string is compared with a frame that the bench builds itself, using the CRC computed as a polynomial remainder.

// File: rtl/cmdfrm_pkg.sv
package cmdfrm_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 24;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LEN_W     = 24;
  localparam int unsigned CRC_W     = 7;
  localparam int unsigned HDR_BYTES = 8;   // longest header before the CRC
  localparam int unsigned HDR_W     = HDR_BYTES * BYTE_W;
  localparam logic [CRC_W-1:0] CRC_SEED = 7'h7F;
  localparam logic [CRC_W-1:0] CRC_TAPS = 7'h09;  // x^3 + 1, x^7 implicit

  typedef enum logic [7:0] {
    OP_DMA_WR  = 8'hC1,
    OP_DMA_RD  = 8'hC2,
    OP_REG_WR  = 8'hC3,
    OP_REG_RD  = 8'hC4,
    OP_TERM    = 8'hC5,
    OP_REPEAT  = 8'hC6,
    OP_XDMA_WR = 8'hC7,
    OP_XDMA_RD = 8'hC8,
    OP_WORD_WR = 8'hC9,
    OP_WORD_RD = 8'hCA,
    OP_RESET   = 8'hCF
  } opcode_e;

  function automatic logic [CRC_W-1:0] crc7_bit(logic [CRC_W-1:0] c, logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
  endfunction
endpackage

// File: rtl/cmdfrm_builder.sv
module cmdfrm_builder
  import cmdfrm_pkg::*;
(
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [LEN_W-1:0]  size_i,
  input  logic              clockless_i,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [3:0]        nbytes_o,
  output logic              valid_o
);
  logic [BYTE_W-1:0] hb [HDR_BYTES];
  logic [BYTE_W-1:0] reg_hi;

  assign reg_hi = {addr_i[15] | clockless_i, addr_i[14:8]};

  always_comb begin
    for (int i = 0; i < HDR_BYTES; i++) hb[i] = '0;
    hb[0]    = opcode_i;
    nbytes_o = 4'd4;
    valid_o  = 1'b1;
    case (opcode_i)
      OP_WORD_RD: begin
        hb[1] = addr_i[23:16]; hb[2] = addr_i[15:8]; hb[3] = addr_i[7:0];
      end
      OP_REG_RD: begin
        hb[1] = reg_hi; hb[2] = addr_i[7:0]; hb[3] = 8'h00;
      end
      OP_TERM, OP_REPEAT: begin
        hb[1] = 8'h00; hb[2] = 8'h00; hb[3] = 8'h00;
      end
      OP_RESET: begin
        hb[1] = 8'hFF; hb[2] = 8'hFF; hb[3] = 8'hFF;
      end
      OP_DMA_WR, OP_DMA_RD: begin
        hb[1] = addr_i[23:16]; hb[2] = addr_i[15:8]; hb[3] = addr_i[7:0];
        hb[4] = size_i[15:8];  hb[5] = size_i[7:0];
        nbytes_o = 4'd6;
      end
      OP_XDMA_WR, OP_XDMA_RD: begin
        hb[1] = addr_i[23:16]; hb[2] = addr_i[15:8]; hb[3] = addr_i[7:0];
        hb[4] = size_i[23:16]; hb[5] = size_i[15:8]; hb[6] = size_i[7:0];
        nbytes_o = 4'd7;
      end
      OP_REG_WR: begin
        hb[1] = reg_hi; hb[2] = addr_i[7:0];
        hb[3] = wdata_i[31:24]; hb[4] = wdata_i[23:16];
        hb[5] = wdata_i[15:8];  hb[6] = wdata_i[7:0];
        nbytes_o = 4'd7;
      end
      OP_WORD_WR: begin
        hb[1] = addr_i[23:16]; hb[2] = addr_i[15:8]; hb[3] = addr_i[7:0];
        hb[4] = wdata_i[31:24]; hb[5] = wdata_i[23:16];
        hb[6] = wdata_i[15:8];  hb[7] = wdata_i[7:0];
        nbytes_o = 4'd8;
      end
      default: valid_o = 1'b0;
    endcase
  end

  // byte 0 lands in the top bits so that the serializer shifts from the MSB
  for (genvar g = 0; g < HDR_BYTES; g++) begin : g_pack
    assign hdr_o[HDR_W-1-g*BYTE_W -: BYTE_W] = hb[g];
  end
endmodule

// File: rtl/cmdfrm_crc7.sv
module cmdfrm_crc7
  import cmdfrm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_d_o
);
  logic [CRC_W-1:0] crc_q;

  always_comb begin
    crc_d_o = crc_q;
    if (clr_i)       crc_d_o = CRC_SEED;
    else if (step_i) crc_d_o = crc7_bit(crc_q, bit_i);
  end

  always_ff @(posedge clk) begin
    if (rst) crc_q <= CRC_SEED;
    else     crc_q <= crc_d_o;
  end

  AST_CRC_SEEDED: assert property (@(posedge clk) disable iff (rst)
    $past(clr_i) |-> (crc_q == CRC_SEED)); // R6
  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !step_i) |=> $stable(crc_q)); // R6
endmodule

// File: rtl/cmdfrm_serializer.sv
module cmdfrm_serializer #(
  parameter int unsigned FRAME_W  = 64,
  parameter int unsigned SCK_HALF = 2,
  parameter int unsigned CNT_W    = $clog2(FRAME_W + 9)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] body_i,
  input  logic [CNT_W-1:0]   dbits_i,
  input  logic               crc_en_i,
  input  logic [6:0]         crc_d_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               cs_n_o,
  output logic               step_o,
  output logic               bit_o
);
  localparam int unsigned HC_W = $clog2(SCK_HALF) + 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(SCK_HALF - 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_idx, dbits_q, nbits_q, nxt_idx, crc_pos;
  logic [HC_W-1:0]    half_cnt;
  logic               phase_hi, half_end, bit_end, last_bit, nxt_mosi;
  logic [7:0]         crc_byte;

  assign half_end = (half_cnt == HC_LAST);
  assign bit_end  = busy_o & phase_hi & half_end;
  assign last_bit = (bit_idx == nbits_q - CNT_W'(1));
  assign nxt_idx  = bit_idx + CNT_W'(1);
  assign crc_pos  = nxt_idx - dbits_q;
  assign crc_byte = {crc_d_i, 1'b0};
  assign nxt_mosi = (nxt_idx < dbits_q) ? shreg[FRAME_W-2]
                                        : crc_byte[3'd7 - crc_pos[2:0]];
  assign step_o   = bit_end & (bit_idx < dbits_q);
  assign bit_o    = shreg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0; done_o <= 1'b0; sck_o <= 1'b0; mosi_o <= 1'b0;
      cs_n_o <= 1'b1; shreg <= '0; bit_idx <= '0; dbits_q <= '0;
      nbits_q <= '0; half_cnt <= '0; phase_hi <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (load_i) begin
          busy_o   <= 1'b1;
          cs_n_o   <= 1'b0;
          shreg    <= body_i;
          bit_idx  <= '0;
          dbits_q  <= dbits_i;
          nbits_q  <= dbits_i + (crc_en_i ? CNT_W'(8) : CNT_W'(0));
          half_cnt <= '0;
          phase_hi <= 1'b0;
          sck_o    <= 1'b0;
          mosi_o   <= body_i[FRAME_W-1];
        end
      end else if (half_end) begin
        half_cnt <= '0;
        if (!phase_hi) begin
          phase_hi <= 1'b1;
          sck_o    <= 1'b1;
        end else begin
          phase_hi <= 1'b0;
          sck_o    <= 1'b0;
          if (last_bit) begin
            busy_o <= 1'b0;
            cs_n_o <= 1'b1;
            done_o <= 1'b1;
            mosi_o <= 1'b0;
          end else begin
            bit_idx <= nxt_idx;
            shreg   <= shreg << 1;
            mosi_o  <= nxt_mosi;
          end
        end
      end else begin
        half_cnt <= half_cnt + HC_W'(1);
      end
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sck_o); // R8
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R8
  AST_BUSY_MATCHES_CS: assert property (@(posedge clk) disable iff (rst)
    busy_o == !cs_n_o); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_CS_RISE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> done_o); // R9
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
  import cmdfrm_pkg::*;
#(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [LEN_W-1:0]  size_i,
  input  logic              clockless_i,
  input  logic              crc_en_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              bad_op_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              cs_n_o
);
  localparam int unsigned CNT_W = $clog2(HDR_W + 9);

  logic [HDR_W-1:0] hdr;
  logic [3:0]       nbytes;
  logic             op_ok, load, step, sbit;
  logic [CRC_W-1:0] crc_d;
  logic [CNT_W-1:0] dbits;

  cmdfrm_builder u_build (
    .opcode_i(opcode_i), .addr_i(addr_i), .wdata_i(wdata_i), .size_i(size_i),
    .clockless_i(clockless_i), .hdr_o(hdr), .nbytes_o(nbytes), .valid_o(op_ok)
  );

  assign load  = start_i & ~busy_o & op_ok;
  assign dbits = CNT_W'({nbytes, 3'b000});

  cmdfrm_crc7 u_crc (
    .clk(clk), .rst(rst), .clr_i(load), .step_i(step), .bit_i(sbit),
    .crc_d_o(crc_d)
  );

  cmdfrm_serializer #(.FRAME_W(HDR_W), .SCK_HALF(SCK_HALF), .CNT_W(CNT_W)) u_ser (
    .clk(clk), .rst(rst), .load_i(load), .body_i(hdr), .dbits_i(dbits),
    .crc_en_i(crc_en_i), .crc_d_i(crc_d), .busy_o(busy_o), .done_o(done_o),
    .sck_o(sck_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o), .step_o(step), .bit_o(sbit)
  );

  always_ff @(posedge clk) begin
    if (rst) bad_op_o <= 1'b0;
    else     bad_op_o <= start_i & ~busy_o & ~op_ok;
  end

  AST_BAD_OP_QUIET: assert property (@(posedge clk) disable iff (rst)
    bad_op_o |-> (cs_n_o && !busy_o)); // R1
  AST_BAD_OP_PULSE: assert property (@(posedge clk) disable iff (rst)
    bad_op_o |=> !bad_op_o); // R1
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> !bad_op_o); // R10
endmodule

// File: tb/tb_spi_cmd_framer.sv
module tb_spi_cmd_framer;
  localparam int HALF = 2;
  localparam realtime TCK = 8ns;

  logic clk = 0, rst = 1, start = 0, cl = 0, ce = 0;
  logic [7:0] op = 0;
  logic [23:0] addr = 0, size = 0;
  logic [31:0] wdata = 0;
  logic busy, done, bad, sck, mosi, cs_n;

  int vecs = 0, fails = 0;
  logic cap [0:127];
  int ncap = 0, mviol = 0;
  logic psck = 0, pmosi = 0;

  always #(TCK/2) clk = ~clk;

  spi_cmd_framer #(.SCK_HALF(HALF)) dut (
    .clk(clk), .rst(rst), .start_i(start), .opcode_i(op), .addr_i(addr),
    .wdata_i(wdata), .size_i(size), .clockless_i(cl), .crc_en_i(ce),
    .busy_o(busy), .done_o(done), .bad_op_o(bad), .sck_o(sck), .mosi_o(mosi),
    .cs_n_o(cs_n)
  );

  always @(negedge clk) begin
    if (!cs_n && sck && !psck && ncap < 128) begin cap[ncap] = mosi; ncap++; end
    if (sck && psck && mosi !== pmosi) mviol++;
    psck = sck; pmosi = mosi;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // remainder of v(z) modulo z^7+z^3+1 for a 15-bit dividend
  function automatic logic [6:0] pmod(input logic [14:0] v);
    logic [14:0] r = v;
    for (int i = 14; i >= 7; i--) if (r[i]) r = r ^ (15'h89 << (i - 7));
    return r[6:0];
  endfunction

  task automatic run_frame(input logic [7:0] o, input logic [23:0] a,
                           input logic [31:0] d, input logic [23:0] s,
                           input logic c, input logic e, input bit intrude);
    logic [7:0] b [0:8];
    int nb;
    bit valid;
    logic [6:0] crc;
    string rq;
    int cnt, nbits;
    bit mism;
    logic [7:0] hi;
    hi = {a[15] | c, a[14:8]};
    for (int i = 0; i < 9; i++) b[i] = 8'h00;
    b[0] = o; valid = 1; nb = 4; rq = "R2";
    case (o)
      8'hCA: begin b[1]=a[23:16]; b[2]=a[15:8]; b[3]=a[7:0]; end
      8'hC4: begin b[1]=hi; b[2]=a[7:0]; rq = "R3"; end
      8'hC5, 8'hC6: ;
      8'hCF: begin b[1]=8'hFF; b[2]=8'hFF; b[3]=8'hFF; end
      8'hC1, 8'hC2: begin b[1]=a[23:16]; b[2]=a[15:8]; b[3]=a[7:0];
                      b[4]=s[15:8]; b[5]=s[7:0]; nb = 6; rq = "R4"; end
      8'hC7, 8'hC8: begin b[1]=a[23:16]; b[2]=a[15:8]; b[3]=a[7:0];
                      b[4]=s[23:16]; b[5]=s[15:8]; b[6]=s[7:0]; nb = 7; rq = "R4"; end
      8'hC3: begin b[1]=hi; b[2]=a[7:0]; b[3]=d[31:24]; b[4]=d[23:16];
               b[5]=d[15:8]; b[6]=d[7:0]; nb = 7; rq = "R3"; end
      8'hC9: begin b[1]=a[23:16]; b[2]=a[15:8]; b[3]=a[7:0]; b[4]=d[31:24];
               b[5]=d[23:16]; b[6]=d[15:8]; b[7]=d[7:0]; nb = 8; rq = "R5"; end
      default: valid = 0;
    endcase
    crc = 7'h7F;
    for (int i = 0; i < nb; i++) crc = pmod({({1'b0, crc} << 1) ^ b[i], 7'b0});
    if (e) begin b[nb] = {crc, 1'b0}; nbits = (nb + 1) * 8; end
    else nbits = nb * 8;

    @(negedge clk);
    op = o; addr = a; wdata = d; size = s; cl = c; ce = e; start = 1; ncap = 0;
    @(negedge clk);
    start = 0;
    if (!valid) begin
      chk(bad === 1'b1 && busy === 1'b0 && cs_n === 1'b1, "R1 bad op flag", bad, 1);
      @(negedge clk);
      chk(bad === 1'b0, "R1 bad op pulse width", bad, 0);
      for (int i = 0; i < 20; i++) @(negedge clk);
      chk(ncap == 0 && cs_n === 1'b1, "R1 nothing sent", ncap, 0);
      return;
    end
    chk(busy === 1'b1 && cs_n === 1'b0 && bad === 1'b0, "R9 busy and cs at strobe", {busy, cs_n}, 2'b10);
    cnt = 1;
    while (done !== 1'b1 && cnt < 2000) begin
      @(negedge clk); cnt++;
      if (intrude && cnt == 5) begin op = 8'hCF; addr = ~a; start = 1; end
      else if (intrude && cnt == 9) begin op = 8'h12; start = 1; end
      else start = 0;
      if (intrude && cnt == 10) chk(bad === 1'b0, "R10 no error while busy", bad, 0);
    end
    start = 0; op = o;
    chk(cnt == nbits * 2 * HALF + 1, "R9 done cycle", cnt, nbits * 2 * HALF + 1);
    chk(cs_n === 1'b1 && busy === 1'b0, "R9 release with done", {cs_n, busy}, 2'b10);
    chk(ncap == nbits, e ? "R6 bit count" : "R7 bit count", ncap, nbits);
    mism = 0;
    for (int i = 0; i < nbits && i < ncap; i++)
      if (cap[i] !== b[i / 8][7 - (i % 8)]) mism = 1;
    if (intrude) rq = "R10";
    chk(!mism, $sformatf("%s frame bits op=%0h crc_en=%0d (R6)", rq, o, e), mism, 0);
    @(negedge clk);
    chk(done === 1'b0, "R9 done pulse width", done, 0);
    if (intrude) begin
      for (int i = 0; i < 10; i++) @(negedge clk);
      chk(cs_n === 1'b1 && ncap == nbits, "R10 no restart", ncap, nbits);
    end
  endtask

  initial begin
    #(TCK * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0 && busy === 1'b0 && done === 1'b0 && bad === 1'b0,
        "R8 reset idle", {cs_n, sck, busy, done, bad}, 5'b10000);
    for (int o = 0; o < 16; o++)
      for (int f = 0; f < 4; f++)
        run_frame(8'hC0 + 8'(o), 24'h5A3C81 ^ (24'(o) * 24'h010307), 32'hDEADBEEF ^ (32'(o) << 8),
                  24'h0401FF + 24'(o * 3), f[0], f[1], 1'b0);
    run_frame(8'h00, 24'h123456, 32'h1, 24'h2, 1'b0, 1'b1, 1'b0);
    run_frame(8'hFF, 24'h123456, 32'h1, 24'h2, 1'b1, 1'b1, 1'b0);
    run_frame(8'hD0, 24'h123456, 32'h1, 24'h2, 1'b0, 1'b0, 1'b0);
    run_frame(8'hC9, 24'hA5F00F, 32'h01234567, 24'h0, 1'b0, 1'b1, 1'b1);
    run_frame(8'hC4, 24'h00FF20, 32'h0, 24'h0, 1'b1, 1'b0, 1'b1);
    chk(mviol == 0, "R8 MOSI stable while SCK high", mviol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule